// File: doc/BRIEF.md
# UDP Receive Header Parser

This block sits behind an IPv4 receive stage. It takes the byte stream that carries the IP payload and splits it into two parts: a record of the UDP header and a stream of UDP payload bytes. A frame is framed by a start strobe from the IP stage. While that strobe is high, the IP stage also presents its decoded header: a valid flag, the protocol number and the source address. Bytes arrive one per cycle with a valid flag and a last flag.

A frame whose protocol is UDP has its first eight bytes consumed as the UDP header. When the header is complete, the block publishes four fields: the source address, the source port, the destination port and the payload length. The payload length is computed from the UDP length field. Every later byte is forwarded through a single register stage with its valid and last flags. A frame with any other protocol produces no output activity at all. Between packets the payload outputs return to zero.

Top module: `udp_rx_parser`

## Requirements
- R1: A frame is parsed only when the IP header valid flag is high and the protocol equals 0x11 at the time the start strobe is first seen. Any other protocol value is ignored.
- R2: The header bytes are taken in stream order, with the most significant byte first in each pair. Bytes 0 and 1 are the source port. Bytes 2 and 3 are the destination port. Bytes 4 and 5 are the UDP length. Bytes 6 and 7 are the checksum, which is discarded.
- R3: The header-valid output rises in the cycle after the edge that samples the eighth header byte. It stays high through the payload. It falls one cycle after either the start strobe or the IP header valid flag goes low.
- R4: The published payload length equals the UDP length minus 8. A UDP length below 8 publishes 0.
- R5: The source address output takes the IP source address presented in the cycle in which the eighth header byte is sampled.
- R6: The UDP start output rises together with header-valid. It falls one cycle after the last payload byte has been presented, or one cycle after the start strobe drops. It never rises for a rejected frame.
- R7: Each payload byte sampled at a clock edge is presented on the output data with valid high during the following cycle. The output last flag copies the input last flag of that byte.
- R8: For a rejected frame, output valid, output last, header-valid and UDP start all stay low for the whole frame.
- R9: Whenever output valid is low, output data is 0x00 and output last is 0. After reset, every output is 0.
- R10: Packets may follow one another with a single idle cycle between them. This includes a UDP packet that follows a rejected frame.
- R11: If the start strobe drops or a last byte arrives before the header is complete, the header position returns to zero. The next frame then parses correctly.
- R12: The published header fields keep their values until the next accepted header completes. A rejected frame leaves them unchanged.
- R13: After a byte flagged last, further input bytes are ignored until the start strobe drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ip_start_i | input | 1 | Frame strobe from the IP stage |
| ip_hdr_ok_i | input | 1 | IP header valid |
| ip_proto_i | input | 8 | IP protocol number |
| ip_src_addr_i | input | 32 | IP source address |
| ip_data_i | input | 8 | Input payload byte |
| ip_valid_i | input | 1 | Input byte valid |
| ip_last_i | input | 1 | Input byte is the last of the frame |
| udp_start_o | output | 1 | Accepted UDP packet in progress |
| hdr_valid_o | output | 1 | Published header fields are valid |
| src_addr_o | output | 32 | Source address of the packet |
| src_port_o | output | 16 | UDP source port |
| dst_port_o | output | 16 | UDP destination port |
| pay_len_o | output | 16 | Payload length in bytes |
| pay_data_o | output | 8 | Payload byte |
| pay_valid_o | output | 1 | Payload byte valid |
| pay_last_o | output | 1 | Final payload byte |

## Verification
The parser is driven with several kinds of frame, and each one separates a different possible fault:
- Accepted UDP packets of different lengths and ports show whether header bytes are ordered and subtracted correctly.
- A frame with protocol 0x12 placed between UDP packets shows whether rejection is complete and whether the held fields survive it.
- A frame cut off partway through the header shows whether the byte position recovers.
- A payload with idle gaps, a frame that keeps sending bytes after its last byte, a length below 8, and an IP header valid flag that drops partway through the payload each exercise one edge of the valid, last, length and clear rules.

// File: rtl/udp_rx_pkg.sv
package udp_rx_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned HDR_LEN  = 8;
  localparam int unsigned IDX_W    = $clog2(HDR_LEN);
  localparam int unsigned FIELD_W  = 2 * BYTE_W;
  localparam int unsigned SHADOW_N = 6;
  localparam logic [7:0]  PROTO_UDP = 8'h11;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_PAY,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/udp_rx_ctrl.sv
module udp_rx_ctrl
  import udp_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hdr_ok_i,
  input  logic [7:0]       proto_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hdr_take_o,
  output logic             hdr_done_o,
  output logic             pay_take_o
);
  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             take, proto_ok, opening, in_hdr;

  always_comb begin
    take       = start_i & valid_i;
    proto_ok   = hdr_ok_i && (proto_i == PROTO_UDP);
    opening    = (phase_q == PH_IDLE) && start_i && hdr_ok_i;
    in_hdr     = (phase_q == PH_HDR) || (opening && proto_ok);
    phase_d    = phase_q;
    idx_d      = idx_q;
    hdr_take_o = 1'b0;
    hdr_done_o = 1'b0;
    pay_take_o = 1'b0;
    if (opening && !proto_ok) phase_d = PH_SKIP;
    if (in_hdr) phase_d = PH_HDR;
    if (in_hdr && take) begin
      hdr_take_o = 1'b1;
      if (idx_q == IDX_W'(HDR_LEN - 1)) begin
        hdr_done_o = 1'b1;
        idx_d      = '0;
        phase_d    = PH_PAY;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
    if ((phase_q == PH_PAY) && take) pay_take_o = 1'b1;
    if (take && last_i) begin
      phase_d = PH_SKIP;
      idx_d   = '0;
    end
    if (!start_i) begin
      phase_d = PH_IDLE;
      idx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign idx_o = idx_q;

  // header position is only non-zero while a header is being collected
  assert_idx_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_HDR) |-> (idx_q == '0));
endmodule

// File: rtl/udp_rx_hdr_cap.sv
module udp_rx_hdr_cap
  import udp_rx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               hdr_ok_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               take_i,
  input  logic               done_i,
  output logic               hv_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [FIELD_W-1:0] sport_o,
  output logic [FIELD_W-1:0] dport_o,
  output logic [FIELD_W-1:0] plen_o
);
  logic [BYTE_W-1:0]  sh_q [SHADOW_N];
  logic [FIELD_W-1:0] len_raw, plen_d;
  logic               hv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SHADOW_N; i++) sh_q[i] <= '0;
    end else if (take_i) begin
      for (int i = 0; i < SHADOW_N; i++)
        if (idx_i == IDX_W'(i)) sh_q[i] <= data_i;
    end
  end

  always_comb begin
    len_raw = {sh_q[4], sh_q[5]};
    plen_d  = (len_raw < FIELD_W'(HDR_LEN)) ? '0 : len_raw - FIELD_W'(HDR_LEN);
    hv_d    = hv_o;
    if (!start_i || !hdr_ok_i) hv_d = 1'b0;
    if (done_i) hv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      sport_o <= '0;
      dport_o <= '0;
      plen_o  <= '0;
    end else if (done_i) begin
      addr_o  <= addr_i;
      sport_o <= {sh_q[0], sh_q[1]};
      dport_o <= {sh_q[2], sh_q[3]};
      plen_o  <= plen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_o <= 1'b0;
    else        hv_o <= hv_d;
  end

  // fields may change only on the cycle header-valid is freshly raised
  assert_fields_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(hv_o) && hv_o |-> $stable(plen_o) && $stable(sport_o));
endmodule

// File: rtl/udp_rx_fwd.sv
module udp_rx_fwd
  import udp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              take_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  output logic              udp_start_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [BYTE_W-1:0] data_d;
  logic              valid_d, last_d, st_d;

  always_comb begin
    valid_d = take_i;
    data_d  = take_i ? data_i : '0;
    last_d  = take_i & last_i;
    st_d    = udp_start_o;
    if (last_o || !start_i) st_d = 1'b0;
    if (done_i) st_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      last_o      <= 1'b0;
      udp_start_o <= 1'b0;
    end else begin
      data_o      <= data_d;
      valid_o     <= valid_d;
      last_o      <= last_d;
      udp_start_o <= st_d;
    end
  end

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (data_o == '0) && !last_o);
endmodule

// File: rtl/udp_rx_parser.sv
module udp_rx_parser
  import udp_rx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ip_start_i,
  input  logic               ip_hdr_ok_i,
  input  logic [7:0]         ip_proto_i,
  input  logic [ADDR_W-1:0]  ip_src_addr_i,
  input  logic [BYTE_W-1:0]  ip_data_i,
  input  logic               ip_valid_i,
  input  logic               ip_last_i,
  output logic               udp_start_o,
  output logic               hdr_valid_o,
  output logic [ADDR_W-1:0]  src_addr_o,
  output logic [FIELD_W-1:0] src_port_o,
  output logic [FIELD_W-1:0] dst_port_o,
  output logic [FIELD_W-1:0] pay_len_o,
  output logic [BYTE_W-1:0]  pay_data_o,
  output logic               pay_valid_o,
  output logic               pay_last_o
);
  logic [IDX_W-1:0] idx;
  logic             hdr_take, hdr_done, pay_take;

  udp_rx_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(ip_start_i), .hdr_ok_i(ip_hdr_ok_i),
    .proto_i(ip_proto_i), .valid_i(ip_valid_i), .last_i(ip_last_i),
    .idx_o(idx), .hdr_take_o(hdr_take), .hdr_done_o(hdr_done), .pay_take_o(pay_take)
  );

  udp_rx_hdr_cap #(.ADDR_W(ADDR_W)) i_cap (
    .clk(clk), .rst_n(rst_n), .start_i(ip_start_i), .hdr_ok_i(ip_hdr_ok_i),
    .addr_i(ip_src_addr_i), .data_i(ip_data_i), .idx_i(idx), .take_i(hdr_take),
    .done_i(hdr_done), .hv_o(hdr_valid_o), .addr_o(src_addr_o),
    .sport_o(src_port_o), .dport_o(dst_port_o), .plen_o(pay_len_o)
  );

  udp_rx_fwd i_fwd (
    .clk(clk), .rst_n(rst_n), .start_i(ip_start_i), .take_i(pay_take),
    .done_i(hdr_done), .data_i(ip_data_i), .last_i(ip_last_i),
    .udp_start_o(udp_start_o), .data_o(pay_data_o), .valid_o(pay_valid_o),
    .last_o(pay_last_o)
  );

  assert_start_with_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udp_start_o) |-> hdr_valid_o);

  assert_pay_in_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid_o |-> udp_start_o);

  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid_o |-> (pay_len_o <= FIELD_W'(16'hFFFF - HDR_LEN)));
endmodule

// File: tb/test_udp_rx_parser.sv
module test_udp_rx_parser;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ip_start = 1'b0, ip_hok = 1'b0, ip_valid = 1'b0, ip_last = 1'b0;
  logic [7:0]  ip_proto = '0, ip_data = '0;
  logic [31:0] ip_addr = '0;
  logic        udp_start, hdr_valid, pay_valid, pay_last;
  logic [31:0] src_addr;
  logic [15:0] src_port, dst_port, pay_len;
  logic [7:0]  pay_data;

  udp_rx_parser i_udp_rx_parser (
    .clk(clk), .rst_n(rst_n), .ip_start_i(ip_start), .ip_hdr_ok_i(ip_hok),
    .ip_proto_i(ip_proto), .ip_src_addr_i(ip_addr), .ip_data_i(ip_data),
    .ip_valid_i(ip_valid), .ip_last_i(ip_last), .udp_start_o(udp_start),
    .hdr_valid_o(hdr_valid), .src_addr_o(src_addr), .src_port_o(src_port),
    .dst_port_o(dst_port), .pay_len_o(pay_len), .pay_data_o(pay_data),
    .pay_valid_o(pay_valid), .pay_last_o(pay_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, beats = 0;
  bit ended = 1'b0, seen_busy = 1'b0, seen_start = 1'b0;
  string tag = "R9";

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference: 0 waiting, 1 header, 2 payload, 3 ignoring
  int ph = 0, nb = 0;
  logic [7:0]  hb [8];
  logic [7:0]  m_data;
  logic        m_valid, m_last, m_hv, m_st;
  logic [31:0] m_addr;
  logic [15:0] m_sp, m_dp, m_len;
  logic [15:0] raw;
  bit          st_clear;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; nb = 0;
      m_data = '0; m_valid = 0; m_last = 0; m_hv = 0; m_st = 0;
      m_addr = '0; m_sp = '0; m_dp = '0; m_len = '0;
    end else begin
      st_clear = m_last || !ip_start;
      m_valid = 0; m_data = '0; m_last = 0;
      if (!ip_start || !ip_hok) m_hv = 0;
      if (st_clear) m_st = 0;
      if (!ip_start) begin
        ph = 0; nb = 0;
      end else begin
        if (ph == 0 && ip_hok) ph = (ip_proto == 8'h11) ? 1 : 3;
        if (ip_valid) begin
          if (ph == 1) begin
            hb[nb] = ip_data;
            nb++;
            if (nb == 8) begin
              raw    = {hb[4], hb[5]};
              m_sp   = {hb[0], hb[1]};
              m_dp   = {hb[2], hb[3]};
              m_len  = (raw < 16'd8) ? 16'd0 : raw - 16'd8;
              m_addr = ip_addr;
              m_hv = 1; m_st = 1; ph = 2; nb = 0;
            end
          end else if (ph == 2) begin
            m_valid = 1; m_data = ip_data; m_last = ip_last;
          end
          if (ip_last) begin ph = 3; nb = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(tag, "pay_valid", pay_valid, m_valid);
      chk(tag, "pay_data",  pay_data,  m_data);
      chk(tag, "pay_last",  pay_last,  m_last);
      chk(tag, "hdr_valid", hdr_valid, m_hv);
      chk(tag, "udp_start", udp_start, m_st);
      chk(tag, "src_addr",  src_addr,  m_addr);
      chk(tag, "src_port",  src_port,  m_sp);
      chk(tag, "dst_port",  dst_port,  m_dp);
      chk(tag, "pay_len",   pay_len,   m_len);
      if (pay_valid) beats++;
      if (pay_valid || pay_last || hdr_valid || udp_start) seen_busy = 1'b1;
      if (udp_start) seen_start = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      fails++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      wrap_up();
    end
  end

  // gap_at: payload index preceded by an idle cycle (-1 none)
  // extra:  bytes sent after last while start stays high
  // hv_drop: payload index at which the IP header valid flag drops (-1 none)
  task automatic send_pkt(input logic [7:0] proto, input logic [31:0] addr,
                          input logic [15:0] sp, input logic [15:0] dp,
                          input logic [15:0] ulen, input int npay,
                          input int gap_at, input int extra, input int hv_drop);
    logic [7:0] hdr [8];
    hdr = '{sp[15:8], sp[7:0], dp[15:8], dp[7:0], ulen[15:8], ulen[7:0], 8'h00, 8'h00};
    beats = 0; seen_busy = 1'b0; seen_start = 1'b0;
    @(negedge clk);
    ip_start = 1; ip_hok = 1; ip_proto = proto; ip_addr = addr; ip_valid = 0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ip_data = hdr[i]; ip_valid = 1; ip_last = (npay == 0 && i == 7);
      @(negedge clk);
    end
    for (int i = 0; i < npay; i++) begin
      if (i == gap_at) begin
        ip_valid = 0; ip_data = 8'h5A; ip_last = 0;
        @(negedge clk);
      end
      if (i == hv_drop) ip_hok = 0;
      ip_data = 8'hA0 + 8'(i) + sp[7:0]; ip_valid = 1; ip_last = (i == npay - 1);
      @(negedge clk);
    end
    ip_valid = 0; ip_last = 0; ip_data = 8'h00;
    for (int i = 0; i < extra; i++) begin
      ip_data = 8'hEE; ip_valid = 1;
      @(negedge clk);
    end
    ip_valid = 0; ip_data = 8'h00;
    @(negedge clk);
    ip_start = 0; ip_hok = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset pay_valid", pay_valid, 0);
    chk("R9", "reset pay_data", pay_data, 0);
    chk("R9", "reset udp_start", udp_start, 0);
    chk("R9", "reset hdr_valid", hdr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R7";
    send_pkt(8'h11, 32'hC0A80501, 16'h1498, 16'h8724, 16'h000B, 3, -1, 0, -1);
    chk("R2", "src_port", src_port, 16'h1498);
    chk("R2", "dst_port", dst_port, 16'h8724);
    chk("R4", "pay_len 0x0B", pay_len, 3);
    chk("R5", "src_addr", src_addr, 32'hC0A80501);
    chk("R7", "beats", beats, 3);
    chk("R6", "start seen", seen_start, 1);

    tag = "R3";
    send_pkt(8'h11, 32'h0A000001, 16'h7623, 16'h0365, 16'h000D, 5, -1, 0, -1);
    chk("R4", "pay_len 0x0D", pay_len, 5);
    chk("R7", "beats", beats, 5);

    tag = "R8";
    send_pkt(8'h12, 32'h0B0B0B0B, 16'h1111, 16'h2222, 16'h000D, 5, -1, 0, -1);
    chk("R8", "no activity on rejected frame", seen_busy, 0);
    chk("R1", "no payload forwarded", beats, 0);
    chk("R12", "held src_port", src_port, 16'h7623);
    chk("R12", "held src_addr", src_addr, 32'h0A000001);

    tag = "R10";
    send_pkt(8'h11, 32'hC0A80501, 16'h1498, 16'h8724, 16'h000B, 3, -1, 0, -1);
    chk("R10", "after reject beats", beats, 3);
    chk("R10", "after reject dst_port", dst_port, 16'h8724);

    tag = "R11";
    @(negedge clk);
    ip_start = 1; ip_hok = 1; ip_proto = 8'h11; ip_addr = 32'h01020304;
    for (int i = 0; i < 4; i++) begin
      ip_data = 8'h33; ip_valid = 1;
      @(negedge clk);
    end
    ip_start = 0; ip_hok = 0; ip_valid = 0;
    @(negedge clk);
    send_pkt(8'h11, 32'h01020304, 16'h4001, 16'h4002, 16'h000A, 2, -1, 0, -1);
    chk("R11", "after truncation src_port", src_port, 16'h4001);
    chk("R11", "after truncation pay_len", pay_len, 2);

    tag = "R4";
    send_pkt(8'h11, 32'h05050505, 16'h0042, 16'h0043, 16'h0005, 1, -1, 0, -1);
    chk("R4", "short length gives zero", pay_len, 0);

    tag = "R13";
    send_pkt(8'h11, 32'h06060606, 16'h0050, 16'h0051, 16'h000C, 4, -1, 3, -1);
    chk("R13", "bytes after last ignored", beats, 4);

    tag = "R9";
    send_pkt(8'h11, 32'h07070707, 16'h0060, 16'h0061, 16'h000E, 6, 2, 0, -1);
    chk("R9", "gap beats", beats, 6);

    tag = "R3";
    send_pkt(8'h11, 32'h08080808, 16'h0070, 16'h0071, 16'h000E, 6, -1, 0, 2);
    chk("R3", "hdr_valid cleared by header flag", hdr_valid, 0);
    chk("R6", "start cleared after frame", udp_start, 0);

    repeat (3) @(negedge clk);
    wrap_up();
  end
endmodule